// File: doc/BRIEF.md
# Iterative Two-Minimum Finder

The block returns the two smallest unsigned words of a set held in an internal buffer. Software-side logic (or a neighbouring block) fills the buffer through a simple write port, then pulses start with the number of live words. The core reads one group of P words per cycle and passes it through a small combinational sorting network. It writes the two smallest survivors of each group back into a compact prefix of the same buffer. Rounds repeat on the shrinking prefix until at most P live words remain. A last group sort then gives the result.

One P-input network is reused on every cycle. Area therefore grows with P and not with the set size, at the cost of a latency that is the total group count over all rounds. Gaps in a partial group are filled with the all-ones word, so padding never displaces a real value.

Top module: `two_min_finder`

## Requirements
- R1: After reset, busy_o and done_o are 0 and both min0_o and min1_o read all-ones.
- R2: While idle, a cycle with ld_en_i high writes ld_data_i to buffer word ld_addr_i. A load presented while busy_o is high is ignored and does not change the result of the run in progress.
- R3: start_i sampled while idle begins a run over the first min(count_i, N_MAX) buffer words, and busy_o is high from the next cycle. A start_i pulse while busy_o is high is ignored.
- R4: At completion, min0_o is the smallest and min1_o the second smallest of the live words, with duplicates counted separately: two equal minima give min0_o == min1_o.
- R5: With fewer than two live words, each missing entry reads as the all-ones word: a count of 0 gives all-ones on both outputs, and a count of 1 gives the word on min0_o and all-ones on min1_o.
- R6: done_o is a one-cycle pulse. It rises in the same cycle that busy_o falls, and busy_o never falls without it.
- R7: done_o rises exactly L cycles after the start edge, where L = 1 + the number of groups processed over all reduction rounds. A reduction round runs while the live count c > P. It uses ceil(c/P) groups, and the next count is the sum over groups of min(group length, 2).
- R8: min0_o and min1_o change only in the cycle done_o is high, and hold their values otherwise.
- R9: In the done cycle min0_o <= min1_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_en_i | input | 1 | Buffer write strobe (idle only) |
| ld_addr_i | input | AW | Buffer word address |
| ld_data_i | input | W | Word to store |
| count_i | input | CW | Number of live words, clamped to N_MAX |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| min0_o | output | W | Smallest value |
| min1_o | output | W | Second smallest value |

## Verification
The bench sweeps every count from 0 to the buffer depth, plus counts above it, over random, all-equal, ascending, descending, all-ones and duplicate-minimum sets. This catches several kinds of error. A design that pads with zero rather than all-ones reports 0 for short or partial sets. One that drops the second copy of a repeated minimum reports the next larger value in min1_o. One that clamps the count wrongly reads stale words. The measured latency is compared with the group count computed in the bench, so a wrong pointer step or round boundary shows up as a cycle mismatch even when the values happen to match. Mid-run loads of zero and restarts check that nothing busy-time leaks into the buffer or the control.

// File: rtl/twomin_pkg.sv
package twomin_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} fsm_e;
endpackage

// File: rtl/twomin_cmp_swap.sv
module twomin_cmp_swap #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic swap;
  assign swap = b_i < a_i;
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/twomin_sort_net.sv
// Odd-even transposition network: P stages sort P words ascending.
module twomin_sort_net #(
  parameter int W = 8,
  parameter int P = 4
) (
  input  logic [W-1:0] d_i [P],
  output logic [W-1:0] q_o [P]
);
  logic [W-1:0] st [P+1][P];

  for (genvar k = 0; k < P; k++) begin : g_in
    assign st[0][k] = d_i[k];
    assign q_o[k]   = st[P][k];
  end

  for (genvar s = 0; s < P; s++) begin : g_stage
    for (genvar j = 0; j < P; j++) begin : g_lane
      if ((j % 2) == (s % 2) && (j + 1) < P) begin : g_cs
        twomin_cmp_swap #(.W(W)) i_cs (
          .a_i (st[s][j]),
          .b_i (st[s][j+1]),
          .lo_o(st[s+1][j]),
          .hi_o(st[s+1][j+1])
        );
      end else if (!((j % 2) != (s % 2) && j >= 1)) begin : g_pass
        assign st[s+1][j] = st[s][j];
      end
    end
  end
endmodule

// File: rtl/twomin_buf.sv
// Register buffer: one load port, one pair-write port, P padded read lanes.
module twomin_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int P     = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = CW + $clog2(P) + 1
) (
  input  logic          clk_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [W-1:0]  ld_data_i,
  input  logic          wp_en_i,
  input  logic          wp_two_i,
  input  logic [CW-1:0] wp_addr_i,
  input  logic [W-1:0]  wp_d0_i,
  input  logic [W-1:0]  wp_d1_i,
  input  logic [CW-1:0] rd_base_i,
  input  logic [CW-1:0] rd_lim_i,
  output logic [W-1:0]  rd_o [P]
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (ld_we_i && ld_addr_i == AW'(i))
        mem[i] <= ld_data_i;
      else if (wp_en_i && wp_addr_i == CW'(i))
        mem[i] <= wp_d0_i;
      else if (wp_en_i && wp_two_i && (IW'(wp_addr_i) + IW'(1)) == IW'(i))
        mem[i] <= wp_d1_i;
    end
  end

  for (genvar k = 0; k < P; k++) begin : g_rd
    logic [IW-1:0] idx;
    assign idx     = IW'(rd_base_i) + IW'(k);
    assign rd_o[k] = (idx < IW'(rd_lim_i)) ? mem[idx[AW-1:0]] : '1;
  end
endmodule

// File: rtl/two_min_finder.sv
module two_min_finder
  import twomin_pkg::*;
#(
  parameter int W     = 8,
  parameter int N_MAX = 16,
  parameter int P     = 4,
  localparam int AW   = $clog2(N_MAX),
  localparam int CW   = $clog2(N_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [W-1:0]  ld_data_i,
  input  logic [CW-1:0] count_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  min0_o,
  output logic [W-1:0]  min1_o
);
  localparam int IW = CW + $clog2(P) + 1;

  fsm_e          state_q;
  logic [CW-1:0] cnt_q, rd_q, wr_q;
  logic          done_q;
  logic [W-1:0]  min0_q, min1_q;

  logic [W-1:0]  grp [P];
  logic [W-1:0]  srt [P];
  logic          run, fin, last, two;
  logic [CW-1:0] step, cnt_start;

  assign run       = state_q == ST_RUN;
  assign fin       = IW'(cnt_q) <= IW'(P);
  assign last      = (IW'(rd_q) + IW'(P)) >= IW'(cnt_q);
  assign two       = (IW'(cnt_q) - IW'(rd_q)) >= IW'(2);
  assign step      = two ? CW'(2) : CW'(1);
  assign cnt_start = (count_i > CW'(N_MAX)) ? CW'(N_MAX) : count_i;

  twomin_buf #(.W(W), .DEPTH(N_MAX), .P(P)) i_buf (
    .clk_i    (clk_i),
    .ld_we_i  (ld_en_i && !run),
    .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i),
    .wp_en_i  (run && !fin),
    .wp_two_i (two),
    .wp_addr_i(wr_q),
    .wp_d0_i  (srt[0]),
    .wp_d1_i  (srt[1]),
    .rd_base_i(rd_q),
    .rd_lim_i (cnt_q),
    .rd_o     (grp)
  );

  twomin_sort_net #(.W(W), .P(P)) i_sort (
    .d_i(grp),
    .q_o(srt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      done_q  <= 1'b0;
      min0_q  <= '1;
      min1_q  <= '1;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q   <= cnt_start;
            rd_q    <= '0;
            wr_q    <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (fin) begin
            min0_q  <= srt[0];
            min1_q  <= srt[1];
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (last) begin
            // survivors form the compact prefix of the next round
            cnt_q <= wr_q + step;
            rd_q  <= '0;
            wr_q  <= '0;
          end else begin
            rd_q <= CW'(IW'(rd_q) + IW'(P));
            wr_q <= wr_q + step;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = run;
  assign done_o = done_q;
  assign min0_o = min0_q;
  assign min1_o = min1_q;
endmodule

// File: rtl/twomin_chk.sv
module twomin_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] min0_o,
  input logic [W-1:0] min1_o
);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r6_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r3_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r9_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (min0_o <= min1_o));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(min0_o) && $stable(min1_o)));
endmodule

bind two_min_finder twomin_chk #(.W(W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .min0_o (min0_o),
  .min1_o (min1_o)
);

// File: tb/test_two_min_finder.sv
`timescale 1ns/1ps
module test_two_min_finder;
  localparam int W  = 8;
  localparam int N  = 16;
  localparam int P  = 4;
  localparam int AW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          ld_en_i;
  logic [AW-1:0] ld_addr_i;
  logic [W-1:0]  ld_data_i;
  logic [CW-1:0] count_i;
  logic          start_i;
  logic          busy_o, done_o;
  logic [W-1:0]  min0_o, min1_o;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] ref_mem [N];

  always #2 clk = ~clk;

  two_min_finder #(.W(W), .N_MAX(N), .P(P)) i_two_min_finder (
    .clk_i(clk), .rst_ni(rst_ni), .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i), .count_i(count_i), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .min0_o(min0_o), .min1_o(min1_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int n);
    int c = n;
    int l = 0;
    while (c > P) begin
      int full = c / P;
      int rem  = c % P;
      l += full + ((rem != 0) ? 1 : 0);
      c = 2 * full + ((rem < 2) ? rem : 2);
    end
    return l + 1;
  endfunction

  task automatic fill(input int pat);
    int m0 = $urandom_range(N - 1);
    int m1 = (m0 + 1 + $urandom_range(N - 2)) % N;
    for (int i = 0; i < N; i++) begin
      case (pat)
        0: ref_mem[i] = W'($urandom_range(255));
        1: ref_mem[i] = 8'h5a;
        2: ref_mem[i] = W'(255 - 7 * i);
        3: ref_mem[i] = W'(4 + $urandom_range(200));
        4: ref_mem[i] = 8'hff;
        default: ref_mem[i] = W'(10 + 3 * i);
      endcase
    end
    if (pat == 3) begin
      ref_mem[m0] = 8'd3;
      ref_mem[m1] = 8'd3;
    end
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_en_i   = 1'b1;
      ld_addr_i = AW'(i);
      ld_data_i = ref_mem[i];
    end
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic run_case(input int req_n, input bit disturb);
    int n = (req_n > N) ? N : req_n;
    int e0 = 255;
    int e1 = 255;
    int c = 0;
    int h0, h1;
    string tg;
    for (int i = 0; i < n; i++) begin
      if (ref_mem[i] < e0) begin e1 = e0; e0 = ref_mem[i]; end
      else if (ref_mem[i] < e1) e1 = ref_mem[i];
    end
    tg = (n < 2) ? "R5" : (disturb ? "R2 R3 R4" : ((req_n > N) ? "R3 R4" : "R4"));
    @(negedge clk);
    start_i = 1'b1;
    count_i = CW'(req_n);
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && c < 200) begin
      if (c == 1) chk(busy_o == 1'b1, "R3 busy after start", busy_o, 1);
      if (disturb && c == 2) begin
        ld_en_i = 1'b1; ld_addr_i = '0; ld_data_i = '0;
        start_i = 1'b1; count_i = CW'(3);
      end else if (disturb && c == 3) begin
        ld_en_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk);
      c++;
    end
    chk(c == exp_lat(n), "R7 latency", c, exp_lat(n));
    chk(min0_o == W'(e0), {tg, " min0"}, min0_o, e0);
    chk(min1_o == W'(e1), {tg, " min1"}, min1_o, e1);
    chk(!busy_o, "R6 busy low at done", busy_o, 0);
    h0 = min0_o;
    h1 = min1_o;
    @(negedge clk);
    chk(!done_o, "R6 done single cycle", done_o, 0);
    repeat (3) @(negedge clk);
    chk(min0_o == W'(h0) && min1_o == W'(h1), "R8 results held", min0_o, h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; ld_en_i = 1'b0; ld_addr_i = '0; ld_data_i = '0;
    count_i = '0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R1 reset flags", {busy_o, done_o}, 0);
    chk(min0_o == '1 && min1_o == '1, "R1 reset results", min0_o, 255);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && min1_o == '1, "R1 after release", min1_o, 255);

    for (int pat = 0; pat < 6; pat++) begin
      for (int n = 0; n <= N; n++) begin
        fill(pat);
        run_case(n, 1'b0);
      end
    end
    for (int n = N + 1; n < (1 << CW); n += 5) begin
      fill(0);
      run_case(n, 1'b0);
    end
    for (int r = 0; r < 4; r++) begin
      fill(r == 0 ? 3 : 0);
      run_case(N, 1'b1);
    end
    for (int r = 0; r < 40; r++) begin
      fill(r % 2 == 0 ? 0 : 3);
      run_case(2 + $urandom_range(N - 2), 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule